// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates five interrupt sources on behalf of a small 8-bit core: external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. Software loads an enable register and a level register. The block then presents the core with at most one vector request at a time, as a registered valid signal and a 16-bit vector address. The core takes the request with an acknowledge and signals the end of a handler with a return pulse.

The vector request behaves like a valid/ready pair: `irq_req` is valid and `irq_ack` is ready. A transfer happens only in a cycle where both are high. The request stays high until such a transfer occurs, and it cannot be stalled. Unlike a data stream, the request may be withdrawn before it is taken. This happens if its source is disabled or a newer winner replaces it. The controller tracks two in-service levels. A low-level handler may be preempted by a high-level request. A high-level handler cannot be preempted.

Top module: `pic_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 0x0000 and neither level is in service.
- R2: The enable register layout is as follows. Bit 7 is the master enable. Bit 0 is external 0, bit 1 is timer 0, bit 2 is external 1, bit 3 is timer 1 and bit 4 is serial. Bits 6 and 5 have no effect. If the master bit is 0, or a source's bit is 0, that source never raises `irq_req`.
- R3: The level register uses bits 4..0 for the same sources as the enable register. A 1 places the source at the high level, and a 0 places it at the low level.
- R4: Within one level, pending requests are chosen in this order: external 0, then timer 0, then external 1, then timer 1, then serial.
- R5: When requests at both levels are pending, the high-level one is presented.
- R6: While a low handler is in service, only high-level sources may request. While a high handler is in service, no source may request.
- R7: The vector for source index k (in the order of R4) is 0x0003 + 8·k. That gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R8: A transfer clears the latched flag of an external or timer source. A serial request is not cleared and requests again once its level is free.
- R9: The serial source requests while `ser_rx` or `ser_tx` is high.
- R10: A return pulse ends the high in-service level if it is set, and otherwise ends the low level.
- R11: A source event is latched at one clock edge, and `irq_req` rises at the next edge. The request holds its vector until transferred. It drops within two edges once the source is disabled.
- R12: When `irq_req` is low, `irq_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Write strobe for the level register |
| pri_wdata | input | 5 | Level register write data |
| hw_evt | input | 4 | One-cycle event pulses: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 |
| ser_rx | input | 1 | Serial receive flag (level, cleared by software) |
| ser_tx | input | 1 | Serial transmit flag (level, cleared by software) |
| irq_req | output | 1 | Vector request (valid) |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_ack | input | 1 | Acknowledge (ready); a transfer occurs when it is high together with irq_req |
| irq_reti | input | 1 | Return-from-handler pulse |

## Verification
Several properties are checked on every cycle: silence under a cleared master enable, no request while the high level is in service, low-level service allowing only high-level requests, every presented vector lying on the 8-byte grid, a transfer setting an in-service bit, an ignored acknowledge leaving service unchanged, and a return with both levels set clearing only the high bit. The polling order, the level choice, the exact vector for each mix of sources, flag clearing versus the persistent serial request, and the withdrawal on disable can only be shown by the bench's scenarios. These are checked against values derived from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // index width for up to eight sources
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned GLB_BIT = 7;

  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;
endpackage

// File: rtl/pic_flags.sv
// Latched request flags for hardware-cleared sources; a new event wins over a clear.
module pic_flags #(
  parameter int NUM_HW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] set_i,
  input  logic [NUM_HW-1:0] clr_i,
  output logic [NUM_HW-1:0] flag_o
);
  for (genvar g = 0; g < NUM_HW; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_o[g] <= 1'b0;
      else if (set_i[g])   flag_o[g] <= 1'b1;
      else if (clr_i[g])   flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pic_pick.sv
// Fixed-order picker: the lowest set index wins.
module pic_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0]             req_i,
  output logic                     found_o,
  output logic [pic_pkg::IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = i[pic_pkg::IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_insvc.sv
// Two in-service bits: a transfer sets its level, a return clears the highest set one.
module pic_insvc (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  pic_pkg::lvl_e    lvl_i,
  input  logic             reti_i,
  output logic [1:0]       isr_o
);
  logic [1:0] isr_nxt;

  always_comb begin
    isr_nxt = isr_o;
    if (reti_i) begin
      if (isr_o[1]) isr_nxt[1] = 1'b0;
      else          isr_nxt[0] = 1'b0;
    end
    if (fire_i) isr_nxt[lvl_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_o <= 2'b00;
    else        isr_o <= isr_nxt;
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int NUM_HW     = 4,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic [7:0]        en_wdata,
  input  logic              pri_we,
  input  logic [NUM_HW:0]   pri_wdata,
  input  logic [NUM_HW-1:0] hw_evt,
  input  logic              ser_rx,
  input  logic              ser_tx,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              irq_reti
);
  import pic_pkg::*;

  localparam int NUM_SRC = NUM_HW + 1;

  logic                en_glb_q;
  logic [NUM_SRC-1:0]  en_src_q;
  logic [NUM_SRC-1:0]  pri_q;
  logic [NUM_HW-1:0]   hw_flag;
  logic [NUM_HW-1:0]   hw_clr;
  logic [NUM_SRC-1:0]  pend;
  logic [NUM_SRC-1:0]  lvl_pend [2];
  logic [1:0]          lvl_found;
  logic [IDX_W-1:0]    lvl_idx [2];
  logic [1:0]          isr_q;
  logic                hi_ok, lo_ok, win_valid;
  lvl_e                win_lvl, lvl_q;
  logic [IDX_W-1:0]    win_idx, idx_q;
  logic [VEC_W-1:0]    win_vec;
  logic                fire;

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_glb_q <= 1'b0;
      en_src_q <= '0;
      pri_q    <= '0;
    end else begin
      if (en_we) begin
        en_glb_q <= en_wdata[GLB_BIT];
        en_src_q <= en_wdata[NUM_SRC-1:0];
      end
      if (pri_we) pri_q <= pri_wdata;
    end
  end

  pic_flags #(.NUM_HW(NUM_HW)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hw_evt),
    .clr_i  (hw_clr),
    .flag_o (hw_flag)
  );

  assign pend        = {ser_rx | ser_tx, hw_flag} & en_src_q & {NUM_SRC{en_glb_q}};
  assign lvl_pend[0] = pend & ~pri_q;
  assign lvl_pend[1] = pend & pri_q;

  for (genvar l = 0; l < 2; l++) begin : g_lvl
    pic_pick #(.N(NUM_SRC)) pick_i (
      .req_i   (lvl_pend[l]),
      .found_o (lvl_found[l]),
      .idx_o   (lvl_idx[l])
    );
  end

  // preemption gate: high blocked by high service, low by any service
  assign hi_ok     = lvl_found[1] & ~isr_q[1];
  assign lo_ok     = lvl_found[0] & ~isr_q[1] & ~isr_q[0];
  assign win_valid = hi_ok | lo_ok;
  assign win_lvl   = hi_ok ? LVL_HI : LVL_LO;
  assign win_idx   = hi_ok ? lvl_idx[1] : lvl_idx[0];
  assign win_vec   = VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE);

  assign fire   = irq_req & irq_ack;
  // serial index lies beyond NUM_HW, so its shift falls off the mask
  assign hw_clr = fire ? (NUM_HW'(1) << idx_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
      lvl_q   <= LVL_LO;
      idx_q   <= '0;
    end else begin
      irq_req <= win_valid & ~fire;
      if (win_valid && !fire) begin
        irq_vec <= win_vec;
        lvl_q   <= win_lvl;
        idx_q   <= win_idx;
      end
    end
  end

  pic_insvc insvc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .lvl_i  (lvl_q),
    .reti_i (irq_reti),
    .isr_o  (isr_q)
  );
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int NUM_SRC    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             irq_reti,
  input logic [VEC_W-1:0] irq_vec,
  input logic             glb_en,
  input logic [1:0]       isr,
  input logic             lvl
);
  // R2
  a_r2_master_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq_req);

  // R6
  a_r6_no_req_under_hi: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !isr[1]);

  // R6
  a_r6_lo_svc_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && isr[0]) |-> lvl);

  // R7
  a_r7_vec_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((int'(irq_vec) - VEC_BASE) % VEC_STRIDE) == 0 &&
                 int'(irq_vec) >= VEC_BASE &&
                 int'(irq_vec) < VEC_BASE + NUM_SRC * VEC_STRIDE));

  // R10
  a_r10_reti_drops_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reti && isr == 2'b11 && !(irq_req && irq_ack)) |=> isr == 2'b01);

  // R12
  a_r12_xfer_sets_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> isr != 2'b00);

  // R12
  a_r12_stray_ack_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && irq_ack && !irq_reti) |=> isr == $past(isr));
endmodule

bind pic_ctrl pic_ctrl_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .NUM_SRC(NUM_SRC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_ack  (irq_ack),
  .irq_reti (irq_reti),
  .irq_vec  (irq_vec),
  .glb_en   (en_glb_q),
  .isr      (isr_q),
  .lvl      (lvl_q)
);

// File: tb/pic_ctrl_tb_top.sv
`timescale 1ns/100ps
module pic_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_we = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic        pri_we = 1'b0;
  logic [4:0]  pri_wdata = '0;
  logic [3:0]  hw_evt = '0;
  logic        ser_rx = 1'b0;
  logic        ser_tx = 1'b0;
  logic        irq_req;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata), .hw_evt(hw_evt),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  // {en[7:0], pri[4:0], evt[3:0], rx, tx, exp_req, exp_vec[15:0]}
  localparam int NV = 14;
  localparam logic [35:0] TBL [NV] = '{
    {8'h9F, 5'h00, 4'b1111, 1'b1, 1'b0, 1'b1, 16'h0003}, // R4 ext0 first
    {8'h9F, 5'h00, 4'b1110, 1'b1, 1'b0, 1'b1, 16'h000B}, // R4 timer0
    {8'h9F, 5'h00, 4'b1100, 1'b1, 1'b0, 1'b1, 16'h0013}, // R4 ext1
    {8'h9F, 5'h00, 4'b1000, 1'b1, 1'b0, 1'b1, 16'h001B}, // R4 timer1
    {8'h9F, 5'h00, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h0023}, // R9 rx only
    {8'h9F, 5'h00, 4'b0000, 1'b0, 1'b1, 1'b1, 16'h0023}, // R9 tx only
    {8'h9F, 5'h10, 4'b1111, 1'b0, 1'b1, 1'b1, 16'h0023}, // R5 serial high
    {8'h9F, 5'h08, 4'b1111, 1'b0, 1'b0, 1'b1, 16'h001B}, // R5 timer1 high
    {8'h1F, 5'h00, 4'b1111, 1'b1, 1'b1, 1'b0, 16'h0000}, // R2 master off
    {8'h9E, 5'h00, 4'b0001, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 ext0 masked
    {8'h9C, 5'h00, 4'b0011, 1'b0, 1'b0, 1'b0, 16'h0000}, // R2 two masked
    {8'hE4, 5'h00, 4'b0111, 1'b0, 1'b0, 1'b1, 16'h0013}, // R2 reserved bits inert
    {8'h9F, 5'h06, 4'b1111, 1'b0, 1'b0, 1'b1, 16'h000B}, // R3 R4 order inside high
    {8'h8F, 5'h00, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0000}  // R2 serial masked
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en_we = 0; pri_we = 0; hw_evt = '0; ser_rx = 0; ser_tx = 0;
    irq_ack = 0; irq_reti = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg(input logic [7:0] en, input logic [4:0] pri);
    en_we = 1; en_wdata = en; pri_we = 1; pri_wdata = pri;
    tick();
    en_we = 0; pri_we = 0;
  endtask

  task automatic pulse(input logic [3:0] ev);
    hw_evt = ev;
    tick();
    hw_evt = '0;
  endtask

  task automatic ack();
    irq_ack = 1; tick(); irq_ack = 0;
  endtask

  task automatic reti();
    irq_reti = 1; tick(); irq_reti = 0;
  endtask

  initial begin
    // watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 req after reset", {15'd0, irq_req}, 16'd0);
    chk("R1 vec after reset", irq_vec, 16'h0000);

    // table of arbitration patterns
    for (int k = 0; k < NV; k++) begin
      do_reset();
      en_we = 1; en_wdata = TBL[k][35:28]; pri_we = 1; pri_wdata = TBL[k][27:23];
      hw_evt = TBL[k][22:19]; ser_rx = TBL[k][18]; ser_tx = TBL[k][17];
      tick();
      en_we = 0; pri_we = 0; hw_evt = '0;
      tick();
      chk($sformatf("R2 R3 R4 R5 R9 entry %0d req", k), {15'd0, irq_req}, {15'd0, TBL[k][16]});
      chk($sformatf("R7 entry %0d vec", k), irq_vec, TBL[k][15:0]);
    end

    // R8: hardware flag cleared on transfer, serial persists
    do_reset();
    cfg(8'h9F, 5'h00);
    pulse(4'b0001); tick();
    chk("R8 ext0 requested", irq_vec, 16'h0003);
    ack();
    chk("R8 req drops on transfer", {15'd0, irq_req}, 16'd0);
    reti(); tick();
    chk("R8 ext0 flag cleared", {15'd0, irq_req}, 16'd0);
    ser_rx = 1; tick(); tick();
    chk("R9 serial requested", irq_vec, 16'h0023);
    ack(); reti(); tick();
    chk("R8 serial persists req", {15'd0, irq_req}, 16'd1);
    chk("R8 serial persists vec", irq_vec, 16'h0023);
    ser_rx = 0; ack(); reti(); tick();
    chk("R8 serial gone after sw clear", {15'd0, irq_req}, 16'd0);

    // R11: hold until transfer, withdraw on disable
    do_reset();
    cfg(8'h9F, 5'h00);
    pulse(4'b1000);
    chk("R11 not yet after one edge", {15'd0, irq_req}, 16'd0);
    tick();
    chk("R11 req one edge later", {15'd0, irq_req}, 16'd1);
    repeat (5) tick();
    chk("R11 req held", {15'd0, irq_req}, 16'd1);
    chk("R11 vec held", irq_vec, 16'h001B);
    cfg(8'h80, 5'h00); tick();
    chk("R11 withdrawn on disable", {15'd0, irq_req}, 16'd0);
    cfg(8'h88, 5'h00); tick();
    chk("R11 back on re-enable", irq_vec, 16'h001B);
    chk("R11 req back on re-enable", {15'd0, irq_req}, 16'd1);

    // R6 / R10: preemption and nested return
    do_reset();
    cfg(8'h9F, 5'h01);              // ext0 high, rest low
    pulse(4'b0010); tick();
    chk("R6 timer0 low req", irq_vec, 16'h000B);
    ack();                          // low in service
    pulse(4'b0100); tick();
    chk("R6 low blocked by low svc", {15'd0, irq_req}, 16'd0);
    pulse(4'b0001); tick();
    chk("R6 high preempts low", irq_vec, 16'h0003);
    chk("R6 high preempts low req", {15'd0, irq_req}, 16'd1);
    ack();                          // high in service
    pulse(4'b0001); tick();
    chk("R6 high blocked by high svc", {15'd0, irq_req}, 16'd0);
    reti(); tick();
    chk("R10 high cleared first", irq_vec, 16'h0003);
    chk("R10 high cleared first req", {15'd0, irq_req}, 16'd1);
    ack(); reti(); tick();
    chk("R10 low still in service", {15'd0, irq_req}, 16'd0);
    reti(); tick();
    chk("R10 low cleared second", irq_vec, 16'h0013);
    chk("R10 low cleared second req", {15'd0, irq_req}, 16'd1);

    // R12: stray acknowledge has no effect
    do_reset();
    cfg(8'h9F, 5'h00);
    ack(); ack();
    pulse(4'b0100); tick();
    chk("R12 stray ack inert", {15'd0, irq_req}, 16'd1);
    chk("R12 stray ack vec", irq_vec, 16'h0013);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule